// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits behind a two-ratio prescaler in a frequency synthesizer loop and turns the prescaler's output pulses into one feedback pulse per total division of N·P + A input cycles. It holds two down-counters. The main counter is loaded with N. The swallow counter is loaded with A. While the swallow counter still holds a count, the modulus-control line stays low, so the prescaler divides by P + 1. After the swallow counter empties, the line goes high and the prescaler divides by P for the rest of the main count.

The prescaler output reaches the block as a one-clock strobe, `pre_pulse`, that is synchronous to `clk`. The programmed ratios `n_prog` and `a_prog` may change at any time. They are captured only at a preset point, so a division cycle never mixes old and new settings. Legal settings keep N between 3 and 2^N_W − 1, with A no larger than N.

Top module: `dual_mod_swallow_ctl`

## Requirements
- R1: While `rst_n` is low, `mod_ctl` and `fb_pulse` are 0. On the first clock edge after reset is released, both counters load `n_prog` and `a_prog`, and `mod_ctl` then equals 1 only if `a_prog` was 0.
- R2: Each division cycle accepts exactly N prescaler strobes. `fb_pulse` is high for the one clock that follows the edge accepting the N-th strobe.
- R3: Within a cycle, `mod_ctl` is 0 while the first A strobes are accepted and 1 while the remaining N − A strobes are accepted.
- R4: The prescaler divides by P when `mod_ctl` is 1 and by P + 1 when it is 0. Under that prescaler, the spacing between successive `fb_pulse` assertions is N·P + A clocks.
- R5: With A = 0, `mod_ctl` is 1 for the whole cycle, including right after the preset.
- R6: With A = N, `mod_ctl` stays 0 for the whole cycle, and the cycle ends on the main count.
- R7: `n_prog` and `a_prog` are sampled only at a preset edge, which is the edge after reset or the edge accepting the final strobe. A change between preset edges has no effect on the running cycle.
- R8: On a clock with no strobe, and outside the post-reset load, `mod_ctl` holds its value and `fb_pulse` is 0 on the next clock.
- R9: `fb_pulse` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_pulse | input | 1 | One-clock strobe for each prescaler output period |
| n_prog | input | N_W | Programmed main count N |
| a_prog | input | A_W | Programmed swallow count A |
| mod_ctl | output | 1 | Modulus select to the prescaler (1: divide by P, 0: divide by P + 1) |
| fb_pulse | output | 1 | One-clock divided feedback pulse |

## Verification
The hardest case to reach is a settings change that lands in the middle of a running cycle. The check must show that the old ratio finishes intact and the new ratio takes over exactly at the next preset. The bench drives a behavioural prescaler that chooses each group length from `mod_ctl` at the start of the group. A change is injected a few clocks into a measured cycle. The bench then counts clocks, accepted strobes and strobes taken while the line was low, first for that cycle and then for the one after it. The A = 0 and A = N corners come from table rows with small N, so their whole cycles are short and are measured in full.

// File: rtl/dmsc_pkg.sv
package dmsc_pkg;

   // Sequencer phase: post-reset load, swallow portion, tail portion
   typedef enum logic [1:0] {
      PH_LOAD    = 2'd0,
      PH_SWALLOW = 2'd1,
      PH_TAIL    = 2'd2
   } phase_t;

   // Phase entered at a preset, chosen from the newly captured swallow count
   function automatic phase_t preset_phase(input logic a_is_zero);
      return a_is_zero ? PH_TAIL : PH_SWALLOW;
   endfunction

endpackage

// File: rtl/dmsc_down_ctr.sv
module dmsc_down_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         at_one
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_width
         $error("dmsc_down_ctr: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign at_one = (cnt_q == ONE);

endmodule

// File: rtl/dmsc_seq.sv
module dmsc_seq
   import dmsc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pre_pulse,
   input  logic   main_at_one,
   input  logic   swal_at_one,
   input  logic   a_is_zero,
   output logic   ctr_load,
   output logic   main_dec,
   output logic   swal_dec,
   output phase_t phase,
   output logic   fb_pulse
);
   phase_t phase_q, phase_d;
   logic   running;
   logic   terminal;
   logic   fb_q;

   assign running  = (phase_q != PH_LOAD);
   assign terminal = running && pre_pulse && main_at_one;
   assign ctr_load = (phase_q == PH_LOAD) || terminal;
   assign main_dec = running && pre_pulse && !main_at_one;
   assign swal_dec = main_dec && (phase_q == PH_SWALLOW);

   always_comb begin
      phase_d = phase_q;
      if (ctr_load) begin
         phase_d = preset_phase(a_is_zero);
      end else if (swal_dec && swal_at_one) begin
         phase_d = PH_TAIL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_LOAD;
         fb_q    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         fb_q    <= terminal;
      end
   end

   assign phase    = phase_q;
   assign fb_pulse = fb_q;

endmodule

// File: rtl/dual_mod_swallow_ctl.sv
module dual_mod_swallow_ctl
   import dmsc_pkg::*;
#(
   parameter int N_W = 10,
   parameter int A_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_pulse,
   input  logic [N_W-1:0] n_prog,
   input  logic [A_W-1:0] a_prog,
   output logic           mod_ctl,
   output logic           fb_pulse
);
   localparam int N_MAX = (1 << N_W) - 1;
   localparam int A_MAX = (1 << A_W) - 1;

   generate
      if (A_W > N_W) begin : g_bad_swallow_width
         $error("dual_mod_swallow_ctl: A_W must not exceed N_W");
      end
      if (N_MAX < 3) begin : g_bad_main_width
         $error("dual_mod_swallow_ctl: N_W too small for a count of 3");
      end
      if (A_MAX < 0) begin : g_bad_a_max
         $error("dual_mod_swallow_ctl: A_W invalid");
      end
   endgenerate

   logic   ctr_load;
   logic   main_dec;
   logic   swal_dec;
   logic   main_at_one;
   logic   swal_at_one;
   logic   a_is_zero;
   phase_t phase;
   logic   seq_loading;

   assign a_is_zero = (a_prog == '0);

   dmsc_down_ctr #(.W(N_W)) u_main_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (n_prog),
      .dec      (main_dec),
      .at_one   (main_at_one)
   );

   dmsc_down_ctr #(.W(A_W)) u_swal_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (a_prog),
      .dec      (swal_dec),
      .at_one   (swal_at_one)
   );

   dmsc_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pre_pulse   (pre_pulse),
      .main_at_one (main_at_one),
      .swal_at_one (swal_at_one),
      .a_is_zero   (a_is_zero),
      .ctr_load    (ctr_load),
      .main_dec    (main_dec),
      .swal_dec    (swal_dec),
      .phase       (phase),
      .fb_pulse    (fb_pulse)
   );

   assign mod_ctl     = (phase == PH_TAIL);
   assign seq_loading = (phase == PH_LOAD);

endmodule

// File: rtl/dmsc_chk.sv
module dmsc_chk #(
   parameter int A_W = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pre_pulse,
   input logic           mod_ctl,
   input logic           fb_pulse,
   input logic [A_W-1:0] a_prog,
   input logic           loading
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!mod_ctl && !fb_pulse));

   // R2
   fb_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |-> $past(pre_pulse));

   // R9
   fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |=> !fb_pulse);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pre_pulse && !loading) |=> ($stable(mod_ctl) && !fb_pulse));

   // R5
   preset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |-> (mod_ctl == ($past(a_prog) == '0)));

endmodule

bind dual_mod_swallow_ctl dmsc_chk #(.A_W(A_W)) u_dmsc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pre_pulse (pre_pulse),
   .mod_ctl   (mod_ctl),
   .fb_pulse  (fb_pulse),
   .a_prog    (a_prog),
   .loading   (seq_loading)
);

// File: tb/dual_mod_swallow_ctl_bench.sv
module dual_mod_swallow_ctl_bench;
   localparam int N_W = 10;
   localparam int A_W = 7;
   localparam int NV  = 8;
   localparam int VN [NV] = '{10, 3, 5, 40, 1023, 1023, 3, 100};
   localparam int VA [NV] = '{ 3, 0, 5, 17,  127,    0, 3,  99};
   localparam int VP [NV] = '{ 4, 2, 3,  8,    2,    3, 16,  2};

   logic           clk = 1'b0;
   logic           rst_n;
   logic           pre_pulse;
   logic [N_W-1:0] n_prog;
   logic [A_W-1:0] a_prog;
   logic           mod_ctl;
   logic           fb_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   int ps_p   = 4;
   bit ps_run = 1'b0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dual_mod_swallow_ctl #(.N_W(N_W), .A_W(A_W)) u_dual_mod_swallow_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre_pulse (pre_pulse),
      .n_prog    (n_prog),
      .a_prog    (a_prog),
      .mod_ctl   (mod_ctl),
      .fb_pulse  (fb_pulse)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural prescaler: group length picked from mod_ctl at group start
   initial begin
      pre_pulse = 1'b0;
      wait (ps_run);
      @(posedge clk); #1;
      forever begin
         int glen;
         glen = mod_ctl ? ps_p : ps_p + 1;
         for (int i = 1; i <= glen; i++) begin
            pre_pulse = (i == glen);
            @(posedge clk); #1;
         end
      end
   end

   task automatic wait_fb();
      do @(negedge clk); while (!fb_pulse);
   endtask

   // Called at the negedge where fb_pulse was seen; runs to the next one
   task automatic measure(output int cyc, output int tot, output int low);
      cyc = 0; tot = 0; low = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (fb_pulse) break;
         if (pre_pulse) begin
            tot++;
            if (!mod_ctl) low++;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int cyc, tot, low;
      string tag;
      rst_n  = 1'b0;
      n_prog = 10'd10;
      a_prog = 7'd3;
      repeat (3) @(negedge clk);
      check("R1 mod_ctl in reset", int'(mod_ctl), 0);
      check("R1 fb_pulse in reset", int'(fb_pulse), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R8 fb_pulse idle", int'(fb_pulse), 0);
      check("R1 mod_ctl after load (A=3)", int'(mod_ctl), 0);
      // R7: swallow setting changed between presets is not picked up
      a_prog = 7'd0;
      repeat (4) @(negedge clk);
      check("R7 mod_ctl after idle A change", int'(mod_ctl), 0);
      a_prog = 7'd3;
      ps_run = 1'b1;

      // Table walk: R2 strobes, R3/R5/R6 low strobes, R4 period
      for (int v = 0; v < NV; v++) begin
         n_prog = N_W'(VN[v]);
         a_prog = A_W'(VA[v]);
         ps_p   = VP[v];
         wait_fb();
         measure(cyc, tot, low);
         check($sformatf("R4 period N=%0d A=%0d P=%0d", VN[v], VA[v], VP[v]),
               cyc, VN[v] * VP[v] + VA[v]);
         check($sformatf("R2 strobes N=%0d", VN[v]), tot, VN[v]);
         if (VA[v] == 0)          tag = "R5";
         else if (VA[v] == VN[v]) tag = "R6";
         else                     tag = "R3";
         check($sformatf("%s low strobes N=%0d A=%0d", tag, VN[v], VA[v]), low, VA[v]);
      end

      // R7: mid-cycle change finishes old ratio, new one starts at preset
      n_prog = 10'd10;
      a_prog = 7'd3;
      ps_p   = 4;
      wait_fb();
      wait_fb();
      fork
         measure(cyc, tot, low);
         begin
            repeat (8) @(negedge clk);
            n_prog = 10'd6;
            a_prog = 7'd2;
         end
      join
      check("R7 period of running cycle", cyc, 43);
      check("R7 low strobes of running cycle", low, 3);
      measure(cyc, tot, low);
      check("R7 period after preset", cyc, 26);
      check("R7 low strobes after preset", low, 2);
      check("R7 strobes after preset", tot, 6);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule